// File: doc/BRIEF.md
# Counter CSR Access Gate

This block holds the cycle/retired-instruction counter state of a processor hart and answers CSR reads and writes aimed at it. One 64-bit counter stands behind both the cycle and the instret names, at user and at machine level. It advances on each retire pulse. A write in the same cycle overrides the step. Two 32-bit enable registers decide which counters software below machine level may read: the machine enable covers supervisor and user code, and the supervisor enable also covers user code. Each is indexed by the low five bits of the counter address.

When the core runs with 32-bit registers, the counter is seen as two halves. The low-half address returns and writes bits 31:0. The high-half address, which is the low address plus 0x80, returns and writes bits 63:32. Performance-monitor counters 3 to 31 and their event selectors are not implemented: they read as zero, and writes to them are dropped. Any access the block cannot honour raises the illegal flag in the same cycle so the core can take an illegal-instruction trap.

Top module: `ctr_csr_gate`

## Requirements
- R1: After reset, the shared counter and both enable registers read as zero.
- R2: The counter grows by exactly one on each cycle with `retire` high. A legal write to the counter in the same cycle takes effect instead of the step. With no retire and no write, the counter holds.
- R3: Addresses 0xC00 and 0xC02 (user) and 0xB00 and 0xB02 (machine) all read the same counter. A write through 0xB00 or 0xB02 is seen at all four.
- R4: Privilege is encoded U=0, S=1, M=3. Machine mode may always read a user counter address 0xC00+i. Supervisor mode needs bit i of the machine enable. User mode needs bit i of both enables, with i = address bits 4:0. A denied read raises `csr_illegal` and returns zero.
- R5: A permitted read of a user performance counter, 0xC03 to 0xC1F (high halves 0xC83 to 0xC9F), returns zero.
- R6: The machine performance counters 0xB03 to 0xB1F, their high halves 0xB83 to 0xB9F, and the event selectors 0x323 to 0x33F read as zero. Writes to them are accepted and change nothing.
- R7: With `mode32`=1, a low-half read returns counter bits 31:0 zero-extended and a high-half read returns bits 63:32 zero-extended. With `mode32`=0, a low-half read returns all 64 bits.
- R8: With `mode32`=1, a low-half write replaces bits 31:0 and keeps 63:32, and a high-half write replaces bits 63:32 with write data 31:0 and keeps 31:0. With `mode32`=0, a write replaces all 64 bits.
- R9: With `mode32`=0, any access to a high-half counter address (address bit 7 set) is illegal.
- R10: An access from a privilege below address bits 9:8 is illegal. A write to an address whose bits 11:10 are 2'b11 is illegal. An illegal access changes no state.
- R11: The machine enable sits at 0x306 (machine only) and the supervisor enable at 0x106 (supervisor or machine). Both are 32 bits wide, readable and writable.
- R12: Any other address, including 0xC01, 0xB01 and 0x320 to 0x322, is illegal and reads zero. With neither strobe high, `csr_illegal` and `csr_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| mode32 | input | 1 | 1 when the core runs with 32-bit registers |
| retire | input | 1 | One instruction retired this cycle |
| csr_rdata | output | 64 | Read data, zero unless a read is legal |
| csr_illegal | output | 1 | The current access is not permitted |

## Verification
The gate is swept over every index of the user counter page, both halves, both register widths and all three privileges. This is repeated under five enable pairs, including all-zero, machine-only and two bit patterns where the machine and supervisor bits disagree. That separates a gate that ignores one enable, or indexes the wrong bit, from a correct one. The counter is preloaded with different upper and lower halves so that a swapped or missing half shows. Retire runs, a write colliding with a retire, and half writes tell a correct step from a stuck counter or a lost step. The performance-monitor and event pages are written with junk and read back to show that they are inert.

// File: rtl/ctr_csr_pkg.sv
// Shared types for the counter CSR gate.
// Assumes privilege uses the common 2-bit encoding, with 2 reserved.
package ctr_csr_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    // Class of an address, as seen by the gate
    typedef enum logic [2:0] {
        CK_NONE,   // not handled here
        CK_UCNT,   // user cycle/instret alias
        CK_UHPM,   // user performance counter (reads zero)
        CK_MCNT,   // machine cycle/instret alias
        CK_MHPM,   // machine performance counter (inert)
        CK_MEVT,   // event selector (inert)
        CK_MEN,    // machine counter enable
        CK_SEN     // supervisor counter enable
    } csr_kind_e;

    localparam logic [3:0]  PAGE_USER_CNT = 4'hC;
    localparam logic [3:0]  PAGE_MACH_CNT = 4'hB;
    localparam logic [6:0]  EVT_BLOCK     = 7'b0011001;
    localparam logic [11:0] ADDR_MEN      = 12'h306;
    localparam logic [11:0] ADDR_SEN      = 12'h106;

endpackage

// File: rtl/ctr_addr_decode.sv
// Sorts a CSR address into the classes the gate handles.
// Assumes counter pages use address bits 6:5 equal to zero and bit 7 as
// the high-half select; index 1 (time) is not handled here.
module ctr_addr_decode
    import ctr_csr_pkg::*;
#(
    parameter int HPM_LO = 3,
    parameter int HPM_HI = 31
) (
    input  logic [11:0] addr,
    output csr_kind_e   kind,
    output logic        hi_half
);
    localparam logic [4:0] LO5 = 5'(HPM_LO);
    localparam logic [4:0] HI5 = 5'(HPM_HI);

    logic [4:0] idx;
    logic       is_main;
    logic       is_hpm;
    logic       user_pg;
    logic       mach_pg;

    assign idx     = addr[4:0];
    assign is_main = (idx == 5'd0) || (idx == 5'd2);
    assign is_hpm  = (idx >= LO5) && (idx <= HI5);
    assign user_pg = (addr[11:8] == PAGE_USER_CNT) && (addr[6:5] == 2'b00);
    assign mach_pg = (addr[11:8] == PAGE_MACH_CNT) && (addr[6:5] == 2'b00);

    // Classify the address
    always_comb begin
        kind    = CK_NONE;
        hi_half = 1'b0;
        if (user_pg || mach_pg) begin
            hi_half = addr[7];
            if (is_main)
                kind = user_pg ? CK_UCNT : CK_MCNT;
            else if (is_hpm)
                kind = user_pg ? CK_UHPM : CK_MHPM;
        end else if (addr == ADDR_MEN) begin
            kind = CK_MEN;
        end else if (addr == ADDR_SEN) begin
            kind = CK_SEN;
        end else if ((addr[11:5] == EVT_BLOCK) && is_hpm) begin
            kind = CK_MEVT;
        end
    end

endmodule

// File: rtl/ctr_access_gate.sv
// Decides whether the current privilege may read counter index idx.
// Machine mode passes always; supervisor needs the machine enable bit;
// user needs both enable bits. The reserved level is treated as supervisor.
module ctr_access_gate
    import ctr_csr_pkg::*;
#(
    parameter int EN_W  = 32,
    localparam int IDX_W = $clog2(EN_W)
) (
    input  logic [1:0]       priv,
    input  logic [EN_W-1:0]  men,
    input  logic [EN_W-1:0]  sen,
    input  logic [IDX_W-1:0] idx,
    output logic             permit
);
    logic [EN_W-1:0] mask;

    // Narrow an all-ones mask by each enable that applies
    always_comb begin
        mask = '1;
        if (priv_e'(priv) != PRIV_M) mask = mask & men;
        if (priv_e'(priv) == PRIV_U) mask = mask & sen;
    end

    assign permit = mask[idx];

endmodule

// File: rtl/ctr_shared_counter.sv
// The single counter behind cycle and instret. Each half can be loaded
// on its own; any load in a cycle wins over the retire step.
module ctr_shared_counter #(
    parameter int CNT_W = 64,
    localparam int HALF = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [HALF-1:0]  lo_data,
    input  logic [HALF-1:0]  hi_data,
    output logic [CNT_W-1:0] count
);
    // Load halves, otherwise step on retire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) count[HALF-1:0]     <= lo_data;
            if (ld_hi) count[CNT_W-1:HALF] <= hi_data;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ctr_csr_gate.sv
// Counter CSR access gate: one shared cycle/instret counter, two counter
// enables, privilege and half-width checks, and zero-reading performance
// counters. Read data and the illegal flag are combinational from the
// current access; writes land at the next clock edge.
module ctr_csr_gate
    import ctr_csr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int EN_W   = 32,
    parameter int HPM_LO = 3,
    parameter int HPM_HI = 31,
    localparam int HALF  = CNT_W / 2,
    localparam int IDX_W = $clog2(EN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [11:0]      csr_addr,
    input  logic             csr_rd,
    input  logic             csr_wr,
    input  logic [CNT_W-1:0] csr_wdata,
    input  logic [1:0]       priv,
    input  logic             mode32,
    input  logic             retire,
    output logic [CNT_W-1:0] csr_rdata,
    output logic             csr_illegal
);
    csr_kind_e        kind;
    logic             hi_half;
    logic             permit;
    logic [CNT_W-1:0] cnt_q;
    logic [EN_W-1:0]  men_q;
    logic [EN_W-1:0]  sen_q;
    logic             access;
    logic             fault;
    logic             ok;
    logic             wr_ok;
    logic             cnt_wlo;
    logic             cnt_whi;
    logic [HALF-1:0]  hi_load;
    logic             ctr_class;
    logic             user_class;
    logic [CNT_W-1:0] view;

    ctr_addr_decode #(.HPM_LO(HPM_LO), .HPM_HI(HPM_HI)) u_dec (
        .addr    (csr_addr),
        .kind    (kind),
        .hi_half (hi_half)
    );

    ctr_access_gate #(.EN_W(EN_W)) u_gate (
        .priv   (priv),
        .men    (men_q),
        .sen    (sen_q),
        .idx    (csr_addr[IDX_W-1:0]),
        .permit (permit)
    );

    assign access     = csr_rd || csr_wr;
    assign user_class = (kind == CK_UCNT) || (kind == CK_UHPM);
    assign ctr_class  = user_class || (kind == CK_MCNT) || (kind == CK_MHPM);

    // Collect every reason to refuse the access
    always_comb begin
        fault = 1'b0;
        if (kind == CK_NONE)                   fault = 1'b1;
        if (priv < csr_addr[9:8])              fault = 1'b1;
        if (csr_wr && csr_addr[11:10] == 2'b11) fault = 1'b1;
        if (user_class && !permit)             fault = 1'b1;
        if (ctr_class && hi_half && !mode32)   fault = 1'b1;
    end

    assign ok          = access && !fault;
    assign csr_illegal = access && fault;
    assign wr_ok       = csr_wr && ok;

    // Counter as seen at the current width and half
    always_comb begin
        if (!mode32)      view = cnt_q;
        else if (hi_half) view = {{HALF{1'b0}}, cnt_q[CNT_W-1:HALF]};
        else              view = {{HALF{1'b0}}, cnt_q[HALF-1:0]};
    end

    // Read mux; zero for inert registers and refused reads
    always_comb begin
        csr_rdata = '0;
        if (csr_rd && ok) begin
            case (kind)
                CK_UCNT, CK_MCNT: csr_rdata = view;
                CK_MEN:           csr_rdata = {{(CNT_W-EN_W){1'b0}}, men_q};
                CK_SEN:           csr_rdata = {{(CNT_W-EN_W){1'b0}}, sen_q};
                default:          csr_rdata = '0;
            endcase
        end
    end

    assign cnt_wlo = wr_ok && (kind == CK_MCNT) && (!mode32 || !hi_half);
    assign cnt_whi = wr_ok && (kind == CK_MCNT) && (!mode32 || hi_half);
    assign hi_load = mode32 ? csr_wdata[HALF-1:0] : csr_wdata[CNT_W-1:HALF];

    ctr_shared_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (retire),
        .ld_lo   (cnt_wlo),
        .ld_hi   (cnt_whi),
        .lo_data (csr_wdata[HALF-1:0]),
        .hi_data (hi_load),
        .count   (cnt_q)
    );

    // Counter enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            men_q <= '0;
            sen_q <= '0;
        end else if (wr_ok) begin
            if (kind == CK_MEN) men_q <= csr_wdata[EN_W-1:0];
            if (kind == CK_SEN) sen_q <= csr_wdata[EN_W-1:0];
        end
    end

endmodule

// File: rtl/ctr_csr_gate_chk.sv
// Properties of the counter CSR gate, bound onto every instance.
module ctr_csr_gate_chk #(
    parameter int CNT_W = 64,
    parameter int EN_W  = 32,
    localparam int HALF = CNT_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [11:0]      csr_addr,
    input logic             csr_rd,
    input logic             csr_wr,
    input logic [1:0]       priv,
    input logic             mode32,
    input logic             retire,
    input logic [CNT_W-1:0] csr_rdata,
    input logic             csr_illegal,
    input logic [CNT_W-1:0] cnt,
    input logic [EN_W-1:0]  men,
    input logic [EN_W-1:0]  sen,
    input logic             wlo,
    input logic             whi
);
    logic ctr_page;
    assign ctr_page = (csr_addr[11:8] == 4'hC || csr_addr[11:8] == 4'hB)
                      && (csr_addr[6:5] == 2'b00);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !wlo && !whi) |=> (cnt == $past(cnt) + 1'b1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !wlo && !whi) |=> $stable(cnt));

    // Covers R6 as well: any legal read of a counter index 3..31 is zero
    assert_hpm_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && !csr_illegal && ctr_page && csr_addr[4:0] >= 5'd3)
        |-> (csr_rdata == '0));

    assert_hi64_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_rd || csr_wr) && !mode32 && ctr_page && csr_addr[7])
        |-> csr_illegal);

    assert_user_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && priv == 2'd0 && csr_addr == 12'hC00 && !(men[0] && sen[0]))
        |-> csr_illegal);

    assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rd && !csr_wr) |-> (!csr_illegal && csr_rdata == '0));

    assert_lo_keeps_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wlo && !whi) |=> (cnt[CNT_W-1:HALF] == $past(cnt[CNT_W-1:HALF])));

    assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr[11:10] == 2'b11) |-> csr_illegal);

    assert_fault_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (!wlo && !whi));

endmodule

bind ctr_csr_gate ctr_csr_gate_chk #(.CNT_W(CNT_W), .EN_W(EN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_rd      (csr_rd),
    .csr_wr      (csr_wr),
    .priv        (priv),
    .mode32      (mode32),
    .retire      (retire),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .cnt         (cnt_q),
    .men         (men_q),
    .sen         (sen_q),
    .wlo         (cnt_wlo),
    .whi         (cnt_whi)
);

// File: tb/sim_ctr_csr_gate.sv
// Sweeping bench for the counter CSR gate; expected values come from a
// requirement-level model of the counter and enable registers.
module sim_ctr_csr_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_rd = 1'b0;
    logic        csr_wr = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [1:0]  priv = 2'd3;
    logic        mode32 = 1'b0;
    logic        retire = 1'b0;
    logic [63:0] csr_rdata;
    logic        csr_illegal;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] m_cnt = '0;
    logic [31:0] m_men = '0;
    logic [31:0] m_sen = '0;

    always #10 clk = ~clk;

    ctr_csr_gate u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .priv(priv), .mode32(mode32),
        .retire(retire), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
    );

    // Requirement-level expectation for one access against the model state
    task automatic expect_access(input logic [11:0] a, input logic rd, input logic wr,
                                 input logic [1:0] pv, input logic m32,
                                 output logic ill, output logic [63:0] val);
        logic [4:0] i;
        logic cnt_pg, user_pg, main_c, hpm_c, evt_c, men_c, sen_c, en_ok, bad;
        i       = a[4:0];
        cnt_pg  = (a[11:8] == 4'hC || a[11:8] == 4'hB) && a[6:5] == 2'b00;
        user_pg = cnt_pg && a[11:8] == 4'hC;
        main_c  = cnt_pg && (i == 5'd0 || i == 5'd2);
        hpm_c   = cnt_pg && i >= 5'd3;
        evt_c   = a[11:5] == 7'b0011001 && i >= 5'd3;
        men_c   = a == 12'h306;
        sen_c   = a == 12'h106;
        en_ok   = (pv == 2'd3) ? 1'b1 : (pv == 2'd1) ? m_men[i] : (m_men[i] & m_sen[i]);
        bad = !(main_c || hpm_c || evt_c || men_c || sen_c)
              || (pv < a[9:8])
              || (wr && a[11:10] == 2'b11)
              || (user_pg && !en_ok)
              || (cnt_pg && a[7] && !m32);
        ill = (rd || wr) && bad;
        val = '0;
        if (rd && !ill) begin
            if (main_c) val = !m32 ? m_cnt : (a[7] ? {32'd0, m_cnt[63:32]} : {32'd0, m_cnt[31:0]});
            else if (men_c) val = {32'd0, m_men};
            else if (sen_c) val = {32'd0, m_sen};
        end
    endtask

    // Drive one cycle, compare the combinational response, then advance the model
    task automatic apply(input logic [11:0] a, input logic rd, input logic wr,
                         input logic [63:0] wd, input logic [1:0] pv, input logic m32,
                         input logic rt, input string tag);
        logic ill;
        logic [63:0] val;
        logic [63:0] nxt;
        @(negedge clk);
        csr_addr = a; csr_rd = rd; csr_wr = wr; csr_wdata = wd;
        priv = pv; mode32 = m32; retire = rt;
        #5;
        expect_access(a, rd, wr, pv, m32, ill, val);
        n_vec++;
        if (csr_illegal !== ill || csr_rdata !== val) begin
            n_bad++;
            $display("FAIL %s addr=%h priv=%0d m32=%0b: got ill=%0b data=%h, want ill=%0b data=%h",
                     tag, a, pv, m32, csr_illegal, csr_rdata, ill, val);
        end
        nxt = m_cnt;
        if (wr && !ill && a[11:8] == 4'hB && (a[4:0] == 5'd0 || a[4:0] == 5'd2) && a[6:5] == 2'b00) begin
            if (!m32)      nxt = wd;
            else if (a[7]) nxt = {wd[31:0], m_cnt[31:0]};
            else           nxt = {m_cnt[63:32], wd[31:0]};
        end else if (rt) begin
            nxt = m_cnt + 64'd1;
        end
        @(posedge clk);
        m_cnt = nxt;
        if (wr && !ill && a == 12'h306) m_men = wd[31:0];
        if (wr && !ill && a == 12'h106) m_sen = wd[31:0];
    endtask

    task automatic rd_at(input logic [11:0] a, input logic [1:0] pv, input logic m32, input string tag);
        apply(a, 1'b1, 1'b0, 64'd0, pv, m32, 1'b0, tag);
    endtask

    task automatic wr_at(input logic [11:0] a, input logic [63:0] wd, input logic [1:0] pv,
                         input logic m32, input string tag);
        apply(a, 1'b0, 1'b1, wd, pv, m32, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_at(12'hB00, 2'd3, 1'b0, "R1");
        rd_at(12'h306, 2'd3, 1'b0, "R1");
        rd_at(12'h106, 2'd3, 1'b0, "R1");

        // R12: idle and unmapped addresses
        apply(12'hC00, 1'b0, 1'b0, 64'd0, 2'd3, 1'b0, 1'b0, "R12");
        rd_at(12'hC01, 2'd3, 1'b0, "R12");
        rd_at(12'hB01, 2'd3, 1'b0, "R12");
        rd_at(12'h320, 2'd3, 1'b0, "R12");
        rd_at(12'h321, 2'd3, 1'b0, "R12");
        rd_at(12'h322, 2'd3, 1'b0, "R12");
        rd_at(12'hC20, 2'd3, 1'b0, "R12");

        // R3, R8: full write through one alias, read through all four
        wr_at(12'hB00, 64'h0123_4567_89AB_CDEF, 2'd3, 1'b0, "R8");
        rd_at(12'hC00, 2'd3, 1'b0, "R3");
        rd_at(12'hC02, 2'd3, 1'b0, "R3");
        rd_at(12'hB02, 2'd3, 1'b0, "R3");
        wr_at(12'hB02, 64'hFFFF_FFFF_FFFF_FFFD, 2'd3, 1'b0, "R3");
        rd_at(12'hB00, 2'd3, 1'b0, "R3");

        // R2: retire steps, carry across 64 bits, write beats retire
        for (int k = 0; k < 5; k++)
            apply(12'hB00, 1'b1, 1'b0, 64'd0, 2'd3, 1'b0, 1'b1, "R2");
        rd_at(12'hB00, 2'd3, 1'b0, "R2");
        apply(12'hB00, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFE, 2'd3, 1'b0, 1'b1, "R2");
        rd_at(12'hB00, 2'd3, 1'b0, "R2");
        for (int k = 0; k < 3; k++)
            apply(12'hC02, 1'b1, 1'b0, 64'd0, 2'd3, 1'b1, 1'b1, "R2");
        rd_at(12'hC80, 2'd3, 1'b1, "R2");

        // R7, R8, R9: halves
        wr_at(12'hB00, 64'hAAAA_BBBB_CCCC_DDDD, 2'd3, 1'b0, "R8");
        rd_at(12'hB00, 2'd3, 1'b1, "R7");
        rd_at(12'hB80, 2'd3, 1'b1, "R7");
        rd_at(12'hC82, 2'd3, 1'b1, "R7");
        wr_at(12'hB02, 64'hFFFF_FFFF_1234_5678, 2'd3, 1'b1, "R8");
        rd_at(12'hB00, 2'd3, 1'b0, "R8");
        wr_at(12'hB82, 64'hEEEE_EEEE_9ABC_DEF0, 2'd3, 1'b1, "R8");
        rd_at(12'hB00, 2'd3, 1'b0, "R8");
        rd_at(12'hB80, 2'd3, 1'b0, "R9");
        wr_at(12'hB80, 64'h5555, 2'd3, 1'b0, "R9");
        rd_at(12'hB00, 2'd3, 1'b0, "R9");

        // R6: inert performance and event registers
        for (int i = 3; i < 32; i++) begin
            wr_at(12'hB00 | 12'(i), 64'hDEAD_BEEF_DEAD_BEEF, 2'd3, 1'b0, "R6");
            wr_at(12'hB80 | 12'(i), 64'hDEAD_BEEF_DEAD_BEEF, 2'd3, 1'b1, "R6");
            wr_at(12'h320 | 12'(i), 64'hDEAD_BEEF_DEAD_BEEF, 2'd3, 1'b0, "R6");
            rd_at(12'hB00 | 12'(i), 2'd3, 1'b0, "R6");
            rd_at(12'hB80 | 12'(i), 2'd3, 1'b1, "R6");
            rd_at(12'h320 | 12'(i), 2'd3, 1'b0, "R6");
        end
        rd_at(12'hB00, 2'd3, 1'b0, "R6");

        // R10, R11: privilege on machine and supervisor registers, read-only page
        rd_at(12'hB00, 2'd1, 1'b0, "R10");
        wr_at(12'hB00, 64'd7, 2'd0, 1'b0, "R10");
        wr_at(12'h306, 64'hFFFF_FFFF, 2'd1, 1'b0, "R10");
        rd_at(12'h306, 2'd3, 1'b0, "R11");
        wr_at(12'h106, 64'h0000_0011, 2'd0, 1'b0, "R10");
        wr_at(12'h106, 64'hFFFF_FFFF_8000_0001, 2'd1, 1'b0, "R11");
        rd_at(12'h106, 2'd1, 1'b0, "R11");
        wr_at(12'hC00, 64'd9, 2'd3, 1'b0, "R10");
        rd_at(12'hB00, 2'd3, 1'b0, "R10");

        // R4, R5, R9: gate sweep over enable pairs, privileges, indices, halves, widths
        wr_at(12'hB00, 64'h1357_9BDF_2468_ACE0, 2'd3, 1'b0, "R4");
        for (int e = 0; e < 5; e++) begin
            logic [31:0] mv, sv;
            case (e)
                0: begin mv = 32'h0;         sv = 32'h0;         end
                1: begin mv = 32'hFFFF_FFFF; sv = 32'h0;         end
                2: begin mv = 32'hFFFF_FFFF; sv = 32'hFFFF_FFFF; end
                3: begin mv = 32'hA5A5_A5A5; sv = 32'h3C3C_3C3C; end
                default: begin mv = 32'h0;   sv = 32'hFFFF_FFFF; end
            endcase
            wr_at(12'h306, {32'd0, mv}, 2'd3, 1'b0, "R11");
            wr_at(12'h106, {32'd0, sv}, 2'd3, 1'b0, "R11");
            for (int p = 0; p < 3; p++) begin
                for (int i = 0; i < 32; i++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [1:0] pv;
                        pv = (p == 2) ? 2'd3 : 2'(p);
                        rd_at(12'hC00 | 12'(i), pv, w[0], (i >= 3) ? "R5" : "R4");
                        rd_at(12'hC80 | 12'(i), pv, w[0], "R9");
                    end
                end
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, want completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule